// File: doc/BRIEF.md
# PCI Unit Interrupt Status Aggregator

This block gathers one-cycle event pulses from the descriptor engines of a PCI interface unit, together with an external INTA level and a bus abort pulse, into a sticky status register. Software reads the status, clears chosen bits by writing ones, selects which sources may interrupt through a mask register, and gates the whole interrupt through a single global enable bit. The result is one level-sensitive interrupt line to the processor.

Alongside the line, the block presents the index of the lowest-numbered source that is both pending and unmasked, with a valid flag. A service routine can use it to dispatch without scanning the status word. Register access is a simple single-cycle write port with a combinational read of the addressed word.

Top module: `pciu_irq_agg`

## Requirements
- R1: Status bit mapping. `desc_evt_i[n]` latches status bit n for n in 0..7 and for n = 9. A `bus_abort_i` pulse latches bit 26. Each source's status bit reads 1 from the first clock edge that samples the pulse. Pulses on `desc_evt_i` bits 8 and 10..15 change nothing.
- R2: Status bits other than 0..7, 9, 25 and 26 always read as zero.
- R3: A write to offset 0x500 clears every status bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0.
- R4: Offset 0x504 holds the mask. Bits 0..7, 9, 25 and 26 are stored as written and all other mask bits read as zero.
- R5: Offset 0x508 bit 0 holds the global enable. Its other bits read as zero.
- R6: `irq_o` is high whenever the enable is 1 and at least one status bit has its mask bit at 1. It stays high with no further events. It is low whenever the enable is 0.
- R7: `pend_idx_o` gives the lowest bit position that is 1 in both status and mask. It does not depend on the enable.
- R8: `pend_valid_o` is 1 exactly when some status bit has its mask bit at 1. When it is 0, `pend_idx_o` is 0.
- R9: When an event and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R10: `ext_inta_i` passes through a two-flop synchronizer. Status bit 25 reads 1 after the third rising edge that sees the input high, and not after the second.
- R11: Status bit 25 cannot be cleared while the synchronized INTA is high. Once the synchronized INTA is low, a clear takes effect.
- R12: After a synchronous reset, status, mask and enable read zero, and `irq_o` and `pend_valid_o` are low.
- R13: Reads of any offset other than the three registers return zero, and writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_evt_i | input | 16 | Descriptor engine event pulses, one cycle each |
| ext_inta_i | input | 1 | External INTA level, asynchronous |
| bus_abort_i | input | 1 | Bus abort event pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Level interrupt to the processor |
| pend_valid_o | output | 1 | Some unmasked status bit is pending |
| pend_idx_o | output | 5 | Index of the lowest pending unmasked bit |

## Verification
The bench drives a clearing write and an event onto the same bit in one cycle. A design where the clear wins would drop the status bit and lose an interrupt. It pulses the unused descriptor lines 8 and 10..15 and writes ones into unused mask bits; an unfiltered design would show phantom status or mask bits, or a pending index with no source behind it. It counts edges from an INTA rise to confirm the two-stage delay, and it tries to clear bit 25 while INTA is still high. A design without the delay would set the bit early, and one without continuous re-latching would let software acknowledge a line that is still asserted. Mask patterns that hide low bits behind higher ones check that the encoder picks the lowest unmasked source and not the lowest raw status bit.

// File: rtl/pciu_irq_pkg.sv
// Package: shared constants and types for the PCI interrupt aggregator.
// Assumes a 32-bit status word with a fixed sparse source map.
package pciu_irq_pkg;
    localparam int unsigned STAT_W    = 32;
    localparam int unsigned IDX_W     = $clog2(STAT_W);
    localparam int unsigned DESC_W    = 16;
    localparam int unsigned INTA_BIT  = 25;
    localparam int unsigned ABORT_BIT = 26;
    // Bits that own a status/mask flop: 0..7, 9, 25, 26.
    localparam logic [STAT_W-1:0] SRC_MAP = 32'h0600_02FF;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_MASK,
        SEL_EN
    } reg_sel_e;
endpackage

// File: rtl/pciu_irq_sync.sv
// Module: multi-stage synchronizer for one asynchronous level.
// Assumes STAGES >= 2; output is the level delayed by STAGES edges.
module pciu_irq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;

    // Shift the input level through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d_i};
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/pciu_irq_status.sv
// Module: sticky status word with write-one-to-clear and set priority.
// Assumes set_i is a per-bit event vector; bits outside IMPL never hold state.
module pciu_irq_status #(
    parameter int unsigned            W    = 32,
    parameter logic [W-1:0]           IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] stat_q;
    logic [W-1:0] stat_nxt;

    // Next value: clear requested bits, then let events override the clear.
    always_comb begin
        stat_nxt = ((stat_q & ~clr_i) | set_i) & IMPL;
    end

    // Hold the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_nxt;
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/pciu_irq_prio.sv
// Module: lowest-index-first priority encoder.
// Assumes W is a power of two and IDX_W = log2(W); index is 0 when idle.
module pciu_irq_prio #(
    parameter int unsigned W     = 32,
    parameter int unsigned IDX_W = 5
) (
    input  logic [W-1:0]     req_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);
    // Scan from the top so the lowest requesting bit is the last assignment.
    always_comb begin
        valid_o = |req_i;
        idx_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/pciu_irq_agg.sv
// Module: PCI unit interrupt status aggregator (top).
// Collects event pulses and a synchronized INTA level into a sticky status
// word, applies a per-bit mask and a global enable, and drives one level
// interrupt plus the lowest pending unmasked index.
// Assumes event pulses are synchronous to clk; ext_inta_i may be asynchronous.
module pciu_irq_agg
    import pciu_irq_pkg::*;
#(
    parameter int unsigned        ADDR_W      = 12,
    parameter int unsigned        SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0]  OFS_STAT    = 12'h500,
    parameter logic [ADDR_W-1:0]  OFS_MASK    = 12'h504,
    parameter logic [ADDR_W-1:0]  OFS_EN      = 12'h508
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DESC_W-1:0]     desc_evt_i,
    input  logic                  ext_inta_i,
    input  logic                  bus_abort_i,
    input  logic                  reg_wr_i,
    input  logic [ADDR_W-1:0]     reg_addr_i,
    input  logic [STAT_W-1:0]     reg_wdata_i,
    output logic [STAT_W-1:0]     reg_rdata_o,
    output logic                  irq_o,
    output logic                  pend_valid_o,
    output logic [IDX_W-1:0]      pend_idx_o
);
    localparam int unsigned GAP_LO_W = INTA_BIT - DESC_W;
    localparam int unsigned GAP_HI_W = STAT_W - ABORT_BIT - 1;

    reg_sel_e          sel;
    logic              inta_s;
    logic [STAT_W-1:0] evt_set;
    logic [STAT_W-1:0] evt_clr;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] mask_q;
    logic              en_q;
    logic [STAT_W-1:0] pend_vec;

    // Decode the register offset.
    always_comb begin
        if      (reg_addr_i == OFS_STAT) sel = SEL_STAT;
        else if (reg_addr_i == OFS_MASK) sel = SEL_MASK;
        else if (reg_addr_i == OFS_EN)   sel = SEL_EN;
        else                             sel = SEL_NONE;
    end

    pciu_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ext_inta_i),
        .q_o   (inta_s)
    );

    // Place each source on its status bit position.
    always_comb begin
        evt_set = {{GAP_HI_W{1'b0}}, bus_abort_i, inta_s,
                   {GAP_LO_W{1'b0}}, desc_evt_i};
        evt_clr = (reg_wr_i && sel == SEL_STAT) ? reg_wdata_i : '0;
    end

    pciu_irq_status #(.W(STAT_W), .IMPL(SRC_MAP)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_set),
        .clr_i  (evt_clr),
        .stat_o (stat_q)
    );

    // Mask register: only mapped source bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                        mask_q <= '0;
        else if (reg_wr_i && sel == SEL_MASK) mask_q <= reg_wdata_i & SRC_MAP;
    end

    // Global enable register: bit 0 only.
    always_ff @(posedge clk) begin
        if (!rst_n)                      en_q <= 1'b0;
        else if (reg_wr_i && sel == SEL_EN) en_q <= reg_wdata_i[0];
    end

    assign pend_vec = stat_q & mask_q;

    pciu_irq_prio #(.W(STAT_W), .IDX_W(IDX_W)) u_prio (
        .req_i   (pend_vec),
        .valid_o (pend_valid_o),
        .idx_o   (pend_idx_o)
    );

    // Interrupt level: a function of flops only, so it cannot glitch on inputs.
    assign irq_o = en_q & pend_valid_o;

    // Read mux for the addressed register.
    always_comb begin
        unique case (sel)
            SEL_STAT: reg_rdata_o = stat_q;
            SEL_MASK: reg_rdata_o = mask_q;
            SEL_EN:   reg_rdata_o = {{(STAT_W-1){1'b0}}, en_q};
            default:  reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/pciu_irq_agg_chk.sv
// Module: property checker for pciu_irq_agg, attached by bind.
// Assumes it observes the top's internal status, mask and enable flops.
module pciu_irq_agg_chk
    import pciu_irq_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] OFS_STAT = 12'h500
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_o,
    input logic              pend_valid_o,
    input logic [IDX_W-1:0]  pend_idx_o,
    input logic [STAT_W-1:0] stat_q,
    input logic [STAT_W-1:0] mask_q,
    input logic              en_q,
    input logic              bus_abort_i,
    input logic              reg_wr_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [STAT_W-1:0] reg_wdata_i
);
    a_r1_abort_latches: assert property (@(posedge clk) disable iff (!rst_n)
        bus_abort_i |=> stat_q[ABORT_BIT]);

    a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & ~SRC_MAP) == '0);

    a_r3_clear_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == OFS_STAT && reg_wdata_i[ABORT_BIT] && !bus_abort_i)
        |=> !stat_q[ABORT_BIT]);

    a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (en_q && pend_valid_o));

    a_r6_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && pend_valid_o) |-> irq_o);

    a_r7_idx_pending: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid_o |-> (stat_q[pend_idx_o] && mask_q[pend_idx_o]));

    a_r7_idx_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid_o |->
            ((stat_q & mask_q & ((32'd1 << pend_idx_o) - 32'd1)) == '0));

    a_r8_idle_index: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_valid_o |-> ((stat_q & mask_q) == '0 && pend_idx_o == '0));
endmodule

bind pciu_irq_agg pciu_irq_agg_chk #(
    .ADDR_W   (ADDR_W),
    .OFS_STAT (OFS_STAT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_o        (irq_o),
    .pend_valid_o (pend_valid_o),
    .pend_idx_o   (pend_idx_o),
    .stat_q       (stat_q),
    .mask_q       (mask_q),
    .en_q         (en_q),
    .bus_abort_i  (bus_abort_i),
    .reg_wr_i     (reg_wr_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i)
);

// File: tb/sim_pciu_irq_agg.sv
// Bench: table-driven source/mask/enable vectors, then directed corner cases.
module sim_pciu_irq_agg;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;
    localparam logic [11:0] A_STAT = 12'h500;
    localparam logic [11:0] A_MASK = 12'h504;
    localparam logic [11:0] A_EN   = 12'h508;
    localparam logic [31:0] MAPPED = 32'h0600_02FF;

    typedef struct packed {
        logic [15:0] desc;
        logic        ab;
        logic [31:0] msk;
        logic        en;
        logic [31:0] xstat;
        logic        xirq;
        logic        xval;
        logic [4:0]  xidx;
    } vec_t;

    // R1, R6, R7, R8 vectors.
    localparam vec_t VEC [8] = '{
        '{16'h0001, 1'b0, 32'hFFFF_FFFF, 1'b1, 32'h0000_0001, 1'b1, 1'b1, 5'd0},
        '{16'h0280, 1'b0, 32'h0000_0200, 1'b1, 32'h0000_0280, 1'b1, 1'b1, 5'd9},
        '{16'h0100, 1'b0, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 5'd0},
        '{16'h0000, 1'b1, 32'h0400_0000, 1'b0, 32'h0400_0000, 1'b0, 1'b1, 5'd26},
        '{16'h00F0, 1'b1, 32'h0400_0000, 1'b1, 32'h0400_00F0, 1'b1, 1'b1, 5'd26},
        '{16'hFC00, 1'b0, 32'h0000_FFFF, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 5'd0},
        '{16'h0066, 1'b0, 32'h0000_0060, 1'b1, 32'h0000_0066, 1'b1, 1'b1, 5'd5},
        '{16'h000C, 1'b0, 32'h0000_0000, 1'b1, 32'h0000_000C, 1'b0, 1'b0, 5'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] desc_evt_i = '0;
    logic        ext_inta_i = 1'b0;
    logic        bus_abort_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [11:0] reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        irq_o;
    logic        pend_valid_o;
    logic [4:0]  pend_idx_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pciu_irq_agg u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .desc_evt_i   (desc_evt_i),
        .ext_inta_i   (ext_inta_i),
        .bus_abort_i  (bus_abort_i),
        .reg_wr_i     (reg_wr_i),
        .reg_addr_i   (reg_addr_i),
        .reg_wdata_i  (reg_wdata_i),
        .reg_rdata_o  (reg_rdata_o),
        .irq_o        (irq_o),
        .pend_valid_o (pend_valid_o),
        .pend_idx_o   (pend_idx_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic pulse(input logic [15:0] dv, input logic ab);
        @(negedge clk);
        desc_evt_i = dv; bus_abort_i = ab;
        @(negedge clk);
        desc_evt_i = '0; bus_abort_i = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;

        // R12: reset state.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(A_STAT, d); chk("R12 status", d, 32'h0);
        rd(A_MASK, d); chk("R12 mask", d, 32'h0);
        rd(A_EN, d);   chk("R12 enable", d, 32'h0);
        chk("R12 irq", {31'b0, irq_o}, 32'h0);
        chk("R12 valid", {31'b0, pend_valid_o}, 32'h0);

        // Vector table walk.
        foreach (VEC[i]) begin
            wr(A_STAT, 32'hFFFF_FFFF);
            wr(A_MASK, VEC[i].msk);
            wr(A_EN, {31'b0, VEC[i].en});
            pulse(VEC[i].desc, VEC[i].ab);
            chk("R6 irq (table)", {31'b0, irq_o}, {31'b0, VEC[i].xirq});
            chk("R8 valid (table)", {31'b0, pend_valid_o}, {31'b0, VEC[i].xval});
            chk("R7 index (table)", {27'b0, pend_idx_o}, {27'b0, VEC[i].xidx});
            rd(A_STAT, d); chk("R1 status map (table)", d, VEC[i].xstat);
            rd(A_MASK, d); chk("R4 mask readback (table)", d, VEC[i].msk & MAPPED);
        end

        // R2 and R5: all-ones writes, unused bits stay zero.
        wr(A_STAT, 32'hFFFF_FFFF);
        pulse(16'hFFFF, 1'b1);
        rd(A_STAT, d); chk("R2 unused status bits", d, 32'h0400_02FF);
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, d); chk("R5 enable bits", d, 32'h1);

        // R3: write-one clears only selected bits.
        wr(A_STAT, 32'hFFFF_FFFF);
        pulse(16'h0007, 1'b0);
        wr(A_STAT, 32'h0000_0002);
        rd(A_STAT, d); chk("R3 clear selected bit", d, 32'h0000_0005);
        wr(A_STAT, 32'h0000_0000);
        rd(A_STAT, d); chk("R3 zero write keeps bits", d, 32'h0000_0005);

        // R13: unmapped offset writes and reads.
        wr(A_MASK, 32'h0000_0001);
        wr(12'h50C, 32'hFFFF_FFFF);
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h50C, d); chk("R13 unmapped read", d, 32'h0);
        rd(A_STAT, d);  chk("R13 status untouched", d, 32'h0000_0005);
        rd(A_MASK, d);  chk("R13 mask untouched", d, 32'h0000_0001);
        rd(A_EN, d);    chk("R13 enable untouched", d, 32'h1);

        // R9: event and clear on the same bit in one cycle.
        pulse(16'h0000, 1'b1);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = A_STAT; reg_wdata_i = 32'h0400_0005;
        desc_evt_i = 16'h0001; bus_abort_i = 1'b1;
        @(negedge clk);
        reg_wr_i = 1'b0; desc_evt_i = '0; bus_abort_i = 1'b0;
        rd(A_STAT, d); chk("R9 set wins over clear", d, 32'h0400_0001);

        // R10: two-stage INTA delay.
        wr(A_STAT, 32'hFFFF_FFFF);
        wr(A_MASK, 32'h0200_0000);
        @(negedge clk);
        ext_inta_i = 1'b1;
        repeat (2) @(negedge clk);
        rd(A_STAT, d); chk("R10 not set after two edges", d, 32'h0);
        @(negedge clk);
        rd(A_STAT, d); chk("R10 set after third edge", d, 32'h0200_0000);
        chk("R10 irq from INTA", {31'b0, irq_o}, 32'h1);

        // R11: clear blocked while INTA high, effective after it drops.
        wr(A_STAT, 32'h0200_0000);
        rd(A_STAT, d); chk("R11 clear blocked while high", d, 32'h0200_0000);
        @(negedge clk);
        ext_inta_i = 1'b0;
        repeat (3) @(negedge clk);
        wr(A_STAT, 32'h0200_0000);
        rd(A_STAT, d); chk("R11 clear after line low", d, 32'h0);

        // R6: level holds, enable gates it, clear releases it.
        wr(A_MASK, 32'h0400_0000);
        pulse(16'h0000, 1'b1);
        repeat (5) @(negedge clk);
        chk("R6 level held", {31'b0, irq_o}, 32'h1);
        wr(A_EN, 32'h0);
        chk("R6 enable off forces low", {31'b0, irq_o}, 32'h0);
        chk("R7 index independent of enable", {27'b0, pend_idx_o}, 32'd26);
        wr(A_EN, 32'h1);
        chk("R6 enable on restores", {31'b0, irq_o}, 32'h1);
        wr(A_STAT, 32'h0400_0000);
        chk("R6 released after clear", {31'b0, irq_o}, 32'h0);
        chk("R8 idle index", {27'b0, pend_idx_o}, 32'h0);

        summary();
        $finish;
    end
endmodule